// File: doc/BRIEF.md
# Broadcast Mesh Processing-Element Tile

A square tile of processing elements that execute one shared instruction per step. Each element keeps two operand registers (A and B) and one result register (P). A result is formed from the element's own operands. Data reaches other elements only through direction-coded moves across an eight-neighbour mesh. A move copies either a result into a neighbour's operand register, or an operand register into the same operand register of a neighbour. A streaming latch shifts operand A one column to the right and brings new samples into the first column. Two compound instructions reduce the tile. Row reduction leaves each row's sum in the last column. Column reduction does the same down the columns, so running it after a row reduction leaves the grand total in the bottom-right element.

Instructions arrive on a valid/ready port and are accepted on a clock edge where both are high. Single-step instructions take effect on that accepting edge. The two reductions are sequenced internally as alternating shift and accumulate phases, and ready stays low until they finish. A load bus writes one row of operands at a time. A read bus returns either one row or one column of result registers, combinationally from the registered state.

Top module: `simd_mesh_tile`

## Requirements
- R1: After reset every element's A, B and P are zero, and `instr_ready` is high.
- R2: Opcode 1 (multiply) sets P of every element to the signed product of the low 16 bits of A and of B, kept to 32 bits.
- R3: Opcode 2 (add) sets P of every element to A + B modulo 2^32.
- R4: Opcode 3 (accumulate) sets P of every element to P + A modulo 2^32.
- R5: Opcode 4 (shift) copies each element's P into A (`instr_sel`=0) or B (`instr_sel`=1) of the neighbour lying in direction `instr_dir`. The codes are 0 up, 1 down, 2 right, 3 left, 4 up-right, 5 up-left, 6 down-right and 7 down-left, with row 0 at the top and column 0 on the left. An element with no source inside the tile receives zero, and all elements read pre-step values.
- R6: Opcode 5 (bypass) copies A (`instr_sel`=0) or B (`instr_sel`=1) into the same register of the neighbour in direction `instr_dir`. It uses the R5 direction codes and the same zero fill at the edge.
- R7: Opcode 6 (latch) loads A of row r, column 0 with the sign-extended 16-bit lane r of `ld_data` (lane k at bits 16k+15:16k). Every other A takes the pre-step A of its left neighbour.
- R8: Opcode 7 (load) writes the sign-extended lane c of `ld_data` into A (`instr_sel`=0) or B (`instr_sel`=1) of column c of row `instr_idx` only. Other rows are unchanged.
- R9: Opcode 8 (row reduction) runs shift-right-P-into-A, then P += A in column k, for k = 1 to 3. Column 0 P is unchanged, column k P becomes the prefix sum of columns 0..k, and column 3 holds the row sum.
- R10: Opcode 9 (column reduction) is the same sequence downward along rows, so after a row reduction, element (3,3) holds the sum of all 16 results.
- R11: After a reduction is accepted, `instr_ready` is low for exactly 5 cycles. Single-step instructions never drop ready.
- R12: With `rd_col`=0, lane j of `rd_data` (bits 32j+31:32j) is P of row `rd_idx`, column j. With `rd_col`=1, lane j is P of row j, column `rd_idx`.
- R13: Opcode 0, opcodes 10 to 15, and cycles with no accepted instruction leave every register unchanged. Shift, bypass, latch and load never change any P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Tile can accept an instruction |
| instr_op | input | 4 | Opcode |
| instr_dir | input | 3 | Direction code for shift and bypass |
| instr_sel | input | 1 | Target operand register: 0 A, 1 B |
| instr_idx | input | 2 | Row index for load |
| ld_data | input | 64 | Four 16-bit sample or operand lanes |
| rd_col | input | 1 | Read orientation: 0 row, 1 column |
| rd_idx | input | 2 | Row or column to read |
| rd_data | output | 128 | Four 32-bit result lanes |

## Verification
A single-step instruction accepted on one edge is complete on that edge. The bench therefore lowers valid at the next falling edge and reads the results from that falling edge onward. A reduction accepted on edge E0 finishes on edge E5. The bench counts the falling edges that see ready low, expects exactly five, and reads only after ready has returned. Operands are never read directly. Each move is checked through the result of the next arithmetic step, and each read is settled one time unit after the read selects change.

// File: rtl/simd_mesh_pkg.sv
package simd_mesh_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_MUL    = 4'd1,
        OP_ADD    = 4'd2,
        OP_ACC    = 4'd3,
        OP_SHIFT  = 4'd4,
        OP_BYPASS = 4'd5,
        OP_LATCH  = 4'd6,
        OP_LOAD   = 4'd7,
        OP_ROWADD = 4'd8,   // internally: accumulate column step_idx
        OP_COLADD = 4'd9    // internally: accumulate row step_idx
    } opcode_e;

    typedef enum logic [2:0] {
        CELL_HOLD,
        CELL_MUL,
        CELL_ADD,
        CELL_ACC,
        CELL_WR_A,
        CELL_WR_B
    } cell_op_e;

    localparam logic [2:0] DIR_UP    = 3'd0;
    localparam logic [2:0] DIR_DOWN  = 3'd1;
    localparam logic [2:0] DIR_RIGHT = 3'd2;
    localparam logic [2:0] DIR_LEFT  = 3'd3;

    // Row motion of data for a direction code (row 0 is the top).
    function automatic int dir_drow(input logic [2:0] d);
        case (d)
            3'd0, 3'd4, 3'd5: return -1;
            3'd1, 3'd6, 3'd7: return 1;
            default:          return 0;
        endcase
    endfunction

    // Column motion of data for a direction code (column 0 is the left).
    function automatic int dir_dcol(input logic [2:0] d);
        case (d)
            3'd2, 3'd4, 3'd6: return 1;
            3'd3, 3'd5, 3'd7: return -1;
            default:          return 0;
        endcase
    endfunction

endpackage

// File: rtl/simd_mesh_pe.sv
module simd_mesh_pe
    import simd_mesh_pkg::*;
#(
    parameter int DW = 16,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cell_op_e      op_i,
    input  logic [PW-1:0] wval_i,
    output logic [PW-1:0] a_o,
    output logic [PW-1:0] b_o,
    output logic [PW-1:0] p_o
);

    typedef struct packed {
        logic [PW-1:0] a;
        logic [PW-1:0] b;
        logic [PW-1:0] p;
    } pe_state_t;

    pe_state_t st_d, st_q;
    logic signed [PW-1:0] a_ext, b_ext;

    always_comb begin
        st_d  = st_q;
        a_ext = PW'($signed(st_q.a[DW-1:0]));
        b_ext = PW'($signed(st_q.b[DW-1:0]));
        unique case (op_i)
            CELL_MUL:  st_d.p = a_ext * b_ext;
            CELL_ADD:  st_d.p = st_q.a + st_q.b;
            CELL_ACC:  st_d.p = st_q.p + st_q.a;
            CELL_WR_A: st_d.a = wval_i;
            CELL_WR_B: st_d.b = wval_i;
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_o = st_q.a;
    assign b_o = st_q.b;
    assign p_o = st_q.p;

endmodule

// File: rtl/simd_mesh_seq.sv
module simd_mesh_seq
    import simd_mesh_pkg::*;
#(
    parameter int DIM = 4,
    parameter int IW  = $clog2(DIM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [3:0]    in_op,
    input  logic [2:0]    in_dir,
    input  logic          in_sel,
    input  logic [IW-1:0] in_idx,
    output opcode_e       step_op,
    output logic [2:0]    step_dir,
    output logic          step_sel,
    output logic [IW-1:0] step_idx
);

    localparam int PHASES = 2 * (DIM - 1);
    localparam int PHW    = $clog2(PHASES + 1);

    typedef struct packed {
        logic           busy;
        logic           col;
        logic [PHW-1:0] phase;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        step_op  = OP_NOP;
        step_dir = '0;
        step_sel = 1'b0;
        step_idx = '0;
        in_ready = !st_q.busy;
        if (st_q.busy) begin
            // even phase: move results one hop; odd phase: accumulate one lane
            if (!st_q.phase[0]) begin
                step_op  = OP_SHIFT;
                step_dir = st_q.col ? DIR_DOWN : DIR_RIGHT;
            end else begin
                step_op  = st_q.col ? OP_COLADD : OP_ROWADD;
                step_idx = IW'((st_q.phase >> 1) + PHW'(1));
            end
            if (st_q.phase == PHW'(PHASES - 1)) begin
                st_d.busy  = 1'b0;
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + PHW'(1);
            end
        end else if (in_valid) begin
            if (in_op == OP_ROWADD || in_op == OP_COLADD) begin
                step_op    = OP_SHIFT;
                step_dir   = (in_op == OP_COLADD) ? DIR_DOWN : DIR_RIGHT;
                st_d.busy  = 1'b1;
                st_d.col   = (in_op == OP_COLADD);
                st_d.phase = PHW'(1);
            end else if (in_op <= 4'd7) begin
                step_op  = opcode_e'(in_op);
                step_dir = in_dir;
                step_sel = in_sel;
                step_idx = in_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/simd_mesh_tile.sv
module simd_mesh_tile
    import simd_mesh_pkg::*;
#(
    parameter int DIM = 4,
    parameter int DW  = 16,
    parameter int PW  = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    output logic                 instr_ready,
    input  logic [3:0]           instr_op,
    input  logic [2:0]           instr_dir,
    input  logic                 instr_sel,
    input  logic [$clog2(DIM)-1:0] instr_idx,
    input  logic [DIM*DW-1:0]    ld_data,
    input  logic                 rd_col,
    input  logic [$clog2(DIM)-1:0] rd_idx,
    output logic [DIM*PW-1:0]    rd_data
);

    localparam int IW = $clog2(DIM);

    opcode_e       step_op;
    logic [2:0]    step_dir;
    logic          step_sel;
    logic [IW-1:0] step_idx;

    logic [PW-1:0] a_q [DIM][DIM];
    logic [PW-1:0] b_q [DIM][DIM];
    logic [PW-1:0] p_q [DIM][DIM];
    logic [DIM*DIM*PW-1:0] p_flat;

    function automatic logic [PW-1:0] sext(input logic [DW-1:0] v);
        return {{(PW-DW){v[DW-1]}}, v};
    endfunction

    simd_mesh_seq #(.DIM(DIM), .IW(IW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (instr_valid),
        .in_ready (instr_ready),
        .in_op    (instr_op),
        .in_dir   (instr_dir),
        .in_sel   (instr_sel),
        .in_idx   (instr_idx),
        .step_op  (step_op),
        .step_dir (step_dir),
        .step_sel (step_sel),
        .step_idx (step_idx)
    );

    for (genvar gr = 0; gr < DIM; gr++) begin : g_row
        for (genvar gc = 0; gc < DIM; gc++) begin : g_col
            localparam int LEFT_C = (gc == 0) ? 0 : gc - 1;

            cell_op_e      c_op;
            logic [PW-1:0] c_wval;
            int            sr, sc;
            logic [PW-1:0] nb_p, nb_a, nb_b;

            always_comb begin
                sr = gr - dir_drow(step_dir);
                sc = gc - dir_dcol(step_dir);
                if (sr >= 0 && sr < DIM && sc >= 0 && sc < DIM) begin
                    nb_p = p_q[sr[IW-1:0]][sc[IW-1:0]];
                    nb_a = a_q[sr[IW-1:0]][sc[IW-1:0]];
                    nb_b = b_q[sr[IW-1:0]][sc[IW-1:0]];
                end else begin
                    nb_p = '0;
                    nb_a = '0;
                    nb_b = '0;
                end
                c_op   = CELL_HOLD;
                c_wval = '0;
                unique case (step_op)
                    OP_MUL: c_op = CELL_MUL;
                    OP_ADD: c_op = CELL_ADD;
                    OP_ACC: c_op = CELL_ACC;
                    OP_SHIFT: begin
                        c_op   = step_sel ? CELL_WR_B : CELL_WR_A;
                        c_wval = nb_p;
                    end
                    OP_BYPASS: begin
                        c_op   = step_sel ? CELL_WR_B : CELL_WR_A;
                        c_wval = step_sel ? nb_b : nb_a;
                    end
                    OP_LATCH: begin
                        c_op   = CELL_WR_A;
                        c_wval = (gc == 0) ? sext(ld_data[gr*DW +: DW])
                                           : a_q[gr][LEFT_C];
                    end
                    OP_LOAD: begin
                        if (step_idx == IW'(gr)) begin
                            c_op   = step_sel ? CELL_WR_B : CELL_WR_A;
                            c_wval = sext(ld_data[gc*DW +: DW]);
                        end
                    end
                    OP_ROWADD: if (step_idx == IW'(gc)) c_op = CELL_ACC;
                    OP_COLADD: if (step_idx == IW'(gr)) c_op = CELL_ACC;
                    default:   c_op = CELL_HOLD;
                endcase
            end

            simd_mesh_pe #(.DW(DW), .PW(PW)) u_pe (
                .clk    (clk),
                .rst_n  (rst_n),
                .op_i   (c_op),
                .wval_i (c_wval),
                .a_o    (a_q[gr][gc]),
                .b_o    (b_q[gr][gc]),
                .p_o    (p_q[gr][gc])
            );

            assign p_flat[(gr*DIM+gc)*PW +: PW] = p_q[gr][gc];
        end
    end

    always_comb begin
        for (int j = 0; j < DIM; j++) begin
            rd_data[j*PW +: PW] = rd_col ? p_q[j][rd_idx] : p_q[rd_idx][j];
        end
    end

endmodule

// File: rtl/simd_mesh_chk.sv
module simd_mesh_chk #(
    parameter int DIM = 4,
    parameter int DW  = 16,
    parameter int PW  = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  instr_valid,
    input logic                  instr_ready,
    input logic [3:0]            instr_op,
    input logic [DIM*DIM*PW-1:0] p_flat,
    input logic [PW-1:0]         a00,
    input logic [PW-1:0]         b00
);

    localparam int BUSY_MAX = 2 * (DIM - 1) - 1;

    logic fire;
    logic [7:0] low_run;
    logic signed [PW-1:0] a00_ext, b00_ext;

    assign fire    = instr_valid && instr_ready;
    assign a00_ext = PW'($signed(a00[DW-1:0]));
    assign b00_ext = PW'($signed(b00[DW-1:0]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            low_run <= '0;
        else if (instr_ready)  low_run <= '0;
        else                   low_run <= low_run + 8'd1;
    end

    AST_REDUCE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (instr_op == 4'd8 || instr_op == 4'd9)) |=> !instr_ready); // R11

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(low_run) <= BUSY_MAX)); // R11

    AST_MOVES_KEEP_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (instr_op == 4'd0 || (instr_op >= 4'd4 && instr_op <= 4'd7) || instr_op >= 4'd10))
        |=> $stable(p_flat)); // R13

    AST_IDLE_KEEPS_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_ready && !instr_valid) |=> $stable(p_flat)); // R13

    AST_CORNER_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && instr_op == 4'd1) |=> (p_flat[PW-1:0] == $past(a00_ext * b00_ext))); // R2

endmodule

bind simd_mesh_tile simd_mesh_chk #(.DIM(DIM), .DW(DW), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_op    (instr_op),
    .p_flat      (p_flat),
    .a00         (a_q[0][0]),
    .b00         (b_q[0][0])
);

// File: tb/simd_mesh_tile_tb.sv
`timescale 1ns/1ps
module simd_mesh_tile_tb;

    localparam int DIM = 4;
    localparam int DW  = 16;
    localparam int PW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              instr_valid = 1'b0;
    logic              instr_ready;
    logic [3:0]        instr_op = '0;
    logic [2:0]        instr_dir = '0;
    logic              instr_sel = 1'b0;
    logic [1:0]        instr_idx = '0;
    logic [DIM*DW-1:0] ld_data = '0;
    logic              rd_col = 1'b0;
    logic [1:0]        rd_idx = '0;
    logic [DIM*PW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [PW-1:0] ma [DIM][DIM];
    logic [PW-1:0] mb [DIM][DIM];
    logic [PW-1:0] mp [DIM][DIM];

    always #2.5 clk = ~clk;

    simd_mesh_tile u_dut (
        .clk (clk), .rst_n (rst_n),
        .instr_valid (instr_valid), .instr_ready (instr_ready),
        .instr_op (instr_op), .instr_dir (instr_dir), .instr_sel (instr_sel),
        .instr_idx (instr_idx), .ld_data (ld_data),
        .rd_col (rd_col), .rd_idx (rd_idx), .rd_data (rd_data)
    );

    function automatic logic [PW-1:0] sx(input logic [DW-1:0] v);
        return {{(PW-DW){v[DW-1]}}, v};
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            1: return "R2";  2: return "R3";  3: return "R4";
            4: return "R5";  5: return "R6";  6: return "R7";
            7: return "R8";  8: return "R9";  9: return "R10";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // source offset: destination (r,c) takes from (r-vr, c-vc)
    task automatic motion(input int dir, output int vr, output int vc);
        vr = 0; vc = 0;
        if (dir == 0 || dir == 4 || dir == 5) vr = -1;
        if (dir == 1 || dir == 6 || dir == 7) vr = 1;
        if (dir == 2 || dir == 4 || dir == 6) vc = 1;
        if (dir == 3 || dir == 5 || dir == 7) vc = -1;
    endtask

    task automatic model(input int op, input int dir, input int sel, input int idx,
                         input logic [DIM*DW-1:0] ld);
        logic [PW-1:0] sa [DIM][DIM];
        logic [PW-1:0] sb [DIM][DIM];
        logic [PW-1:0] sp [DIM][DIM];
        int vr, vc;
        sa = ma; sb = mb; sp = mp;
        motion(dir, vr, vc);
        for (int r = 0; r < DIM; r++) begin
            for (int c = 0; c < DIM; c++) begin
                int fr, fc;
                bit inside_t;
                logic [PW-1:0] v;
                fr = r - vr; fc = c - vc;
                inside_t = (fr >= 0 && fr < DIM && fc >= 0 && fc < DIM);
                case (op)
                    1: mp[r][c] = PW'($signed(sa[r][c][DW-1:0])) * PW'($signed(sb[r][c][DW-1:0]));
                    2: mp[r][c] = sa[r][c] + sb[r][c];
                    3: mp[r][c] = sp[r][c] + sa[r][c];
                    4: begin
                        v = inside_t ? sp[fr][fc] : '0;
                        if (sel == 0) ma[r][c] = v; else mb[r][c] = v;
                    end
                    5: begin
                        if (sel == 0) ma[r][c] = inside_t ? sa[fr][fc] : '0;
                        else          mb[r][c] = inside_t ? sb[fr][fc] : '0;
                    end
                    6: ma[r][c] = (c == 0) ? sx(ld[r*DW +: DW]) : sa[r][c-1];
                    7: if (r == idx) begin
                        if (sel == 0) ma[r][c] = sx(ld[c*DW +: DW]);
                        else          mb[r][c] = sx(ld[c*DW +: DW]);
                    end
                    default: ;
                endcase
            end
        end
        if (op == 8 || op == 9) begin
            for (int k = 1; k < DIM; k++) begin
                sp = mp;
                for (int r = 0; r < DIM; r++)
                    for (int c = 0; c < DIM; c++)
                        if (op == 8) ma[r][c] = (c == 0) ? '0 : sp[r][c-1];
                        else         ma[r][c] = (r == 0) ? '0 : sp[r-1][c];
                for (int j = 0; j < DIM; j++)
                    if (op == 8) mp[j][k] = mp[j][k] + ma[j][k];
                    else         mp[k][j] = mp[k][j] + ma[k][j];
            end
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < DIM; i++) begin
            rd_col = 1'b0; rd_idx = 2'(i); #1;
            for (int j = 0; j < DIM; j++) check(tag, rd_data[j*PW +: PW], mp[i][j]);
        end
        begin
            int cc;
            cc = int'($urandom % DIM);
            rd_col = 1'b1; rd_idx = 2'(cc); #1;
            for (int j = 0; j < DIM; j++) check("R12", rd_data[j*PW +: PW], mp[j][cc]);
        end
    endtask

    task automatic issue(input int op, input int dir, input int sel, input int idx,
                         input logic [DIM*DW-1:0] ld);
        int low;
        while (!instr_ready) @(negedge clk);
        instr_op = 4'(op); instr_dir = 3'(dir); instr_sel = sel[0];
        instr_idx = 2'(idx); ld_data = ld; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        low = 0;
        while (!instr_ready && low < 100) begin low++; @(negedge clk); end
        if (op == 8 || op == 9) check("R11", PW'(low), PW'(2*(DIM-1)-1));
        else                    check("R11", PW'(low), '0);
        model(op, dir, sel, idx, ld);
        check_all(tag_of(op));
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [PW-1:0] total;
        logic [PW-1:0] rsum [DIM];
        void'($urandom(32'd20240611));
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) begin ma[r][c] = '0; mb[r][c] = '0; mp[r][c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", PW'(instr_ready), PW'(1));
        check_all("R1");

        // directed: operands with sign corners, products, moves, reductions
        issue(7, 0, 0, 0, {16'h8000, 16'h7fff, 16'hffff, 16'h0003});
        issue(7, 0, 1, 0, {16'h8000, 16'h0002, 16'hffff, 16'hfffe});
        for (int r = 1; r < DIM; r++) begin
            issue(7, 0, 0, r, {16'(r*7+1), 16'(r+2), 16'hfff0 + 16'(r), 16'(r*3)});
            issue(7, 0, 1, r, {16'(r+5), 16'hffff - 16'(r), 16'(r*11), 16'(9)});
        end
        issue(1, 0, 0, 0, '0);   // R2
        issue(2, 0, 0, 0, '0);   // R3
        for (int d = 0; d < 8; d++) begin
            issue(4, d, d % 2, 0, '0);   // R5 every direction
            issue(3, 0, 0, 0, '0);       // R4 exposes moved A
        end
        issue(5, 2, 0, 0, '0);   // R6
        issue(5, 7, 1, 0, '0);
        issue(1, 0, 0, 0, '0);
        issue(6, 0, 0, 0, {16'h0011, 16'h8001, 16'h0033, 16'h0044});  // R7
        issue(3, 0, 0, 0, '0);
        issue(1, 0, 0, 0, '0);
        total = '0;
        for (int r = 0; r < DIM; r++) begin
            rsum[r] = '0;
            for (int c = 0; c < DIM; c++) rsum[r] += mp[r][c];
            total += rsum[r];
        end
        issue(8, 0, 0, 0, '0);   // R9
        rd_col = 1'b1; rd_idx = 2'(DIM-1); #1;
        for (int r = 0; r < DIM; r++) check("R9", rd_data[r*PW +: PW], rsum[r]);
        issue(9, 0, 0, 0, '0);   // R10
        rd_col = 1'b0; rd_idx = 2'(DIM-1); #1;
        check("R10", rd_data[(DIM-1)*PW +: PW], total);
        repeat (4) @(negedge clk);
        check_all("R13");        // idle cycles hold state
        issue(0, 0, 0, 0, '0);
        issue(12, 3, 1, 2, 64'hffff_ffff_ffff_ffff);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int pick, op;
            pick = int'($urandom % 16);
            case (pick)
                0, 1, 2, 3, 4: op = 7;
                5, 15:         op = 1;
                6:             op = 2;
                7:             op = 3;
                8:             op = 4;
                9:             op = 5;
                10:            op = 6;
                11:            op = 8;
                12:            op = 9;
                13:            op = 0;
                default:       op = 10 + int'($urandom % 6);
            endcase
            issue(op, int'($urandom % 8), int'($urandom % 2), int'($urandom % DIM),
                  {$urandom, $urandom});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule